// File: doc/BRIEF.md
# Two-Level Address Translation Lookup with Permission Check

This block turns a 32-bit virtual address into a physical address by searching two fully associative translation arrays: a small instruction array that is tried first on instruction fetches, and a larger unified array that serves every access. Each entry carries its own page size, so one array can hold 1 KB, 4 KB, 64 KB and 1 MB pages together. An entry also holds an address-space identifier, a shared flag, a valid flag, a dirty flag and a 2-bit protection code.

A request is accepted in one cycle. It carries a write flag, a fetch flag and a probe flag. The search and the permission check are combinational, and the result is registered, so the response appears one cycle later. The response is either a physical address or a coded exception. A probe never raises an exception: it only reports that a fault exists and returns a zero address.

The block also keeps a replacement counter for software-managed refills of the unified array. When an instruction fetch misses the instruction array but hits the unified array, the block copies that unified entry into a pseudo-randomly chosen instruction slot. Entries are loaded through a plain register write port.

Top module: `tlb_unit`

## Requirements
- R1: After reset, rsp_valid is 0, repl_count is 0 and every entry of both arrays is invalid.
- R2: The 2-bit size field selects the compare mask: 0 gives 0xFFFFFC00 (1 KB), 1 gives 0xFFFFF000 (4 KB), 2 gives 0xFFFF0000 (64 KB) and 3 gives 0xFFF00000 (1 MB). Only the address bits under the mask take part in the tag compare.
- R3: An entry whose valid flag is clear never matches.
- R4: A matching entry must also carry an identifier equal to cur_asid. This check is skipped when the entry's shared flag is set, or when single_virt and priv_mode are both 1.
- R5: On a hit without fault, rsp_paddr = (vaddr & ~mask) | (entry data & mask & 0x1FFFFFFF).
- R6: A fetch looks in the instruction array before the unified array, and rsp_itlb_hit reports a hit in the instruction array. A fetch that hits only in the unified array copies that entry into one instruction slot, so a repeated fetch to the same page reports rsp_itlb_hit = 1. Data accesses never use the instruction array and report rsp_itlb_hit = 0.
- R7: A fetch in privileged mode is always allowed. In user mode a fetch raises a load protection fault unless bit 1 of the protection code is set.
- R8: For a privileged data access, codes 0 and 2 are read-only, so a write raises a store protection fault. Codes 1 and 3 allow writes, but a write to an entry whose dirty flag is clear raises a first-write fault.
- R9: For a user data access, codes 0 and 1 fault on both loads and stores (load or store protection fault), code 2 is read-only, and code 3 allows reads and writes under the same dirty-flag rule for writes.
- R10: rsp_exc uses these codes: 0 none, 1 load miss, 2 store miss, 3 load protection, 4 store protection, 5 first write. On a miss, a write gives the store-miss code and a read gives the load-miss code. A fetch counts as a read whatever the write flag says.
- R11: Every accepted request without the probe flag advances repl_count by one. The counter wraps to 0 when the incremented value equals the unified entry count, or equals repl_bound while repl_bound is nonzero. Probes and idle cycles leave it unchanged.
- R12: Any fault returns rsp_paddr = 0 and rsp_fault = 1. A probe reports rsp_exc = 0 even when it faults.
- R13: rsp_valid is 1 exactly in the cycle after a cycle with req_valid = 1. An entry write takes effect at the clock edge that ends its cycle, and an explicit write to the instruction array uses the low bits of ent_index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | Access is a store |
| req_fetch | input | 1 | Access is an instruction fetch |
| req_probe | input | 1 | Report the result without raising an exception |
| cur_asid | input | 8 | Current address-space identifier |
| priv_mode | input | 1 | Requester is privileged |
| single_virt | input | 1 | Single virtual space mode (waives the identifier check when privileged) |
| repl_bound | input | 6 | Replacement counter boundary, 0 = none |
| ent_wr_utlb | input | 1 | Write the entry fields into the unified array |
| ent_wr_itlb | input | 1 | Write the entry fields into the instruction array |
| ent_index | input | 6 | Entry index to write |
| ent_valid | input | 1 | Entry valid flag |
| ent_vtag | input | 32 | Entry virtual tag |
| ent_asid | input | 8 | Entry identifier |
| ent_pdata | input | 32 | Entry physical page data |
| ent_size | input | 2 | Entry page size code |
| ent_prot | input | 2 | Entry protection code |
| ent_shared | input | 1 | Entry shared flag |
| ent_dirty | input | 1 | Entry dirty flag |
| rsp_valid | output | 1 | Response valid |
| rsp_paddr | output | 32 | Physical address, zero on a fault |
| rsp_exc | output | 3 | Exception code |
| rsp_fault | output | 1 | The lookup faulted |
| rsp_itlb_hit | output | 1 | The result came from the instruction array |
| repl_count | output | 6 | Replacement counter |

## Verification
The assertions assume that no two valid entries of one array match the same request, because a lowest-index pick then stands in for behaviour left undefined. The stimulus gives every page a distinct tag and identifier setting to keep to that. They also assume that control inputs are known whenever req_valid is high, and the bench drives all of them from tasks away from the clock edge. The refill slot is pseudo-random, so the bench never rewrites a unified entry that could have been copied into the instruction array, and it predicts rsp_itlb_hit only where the slot choice cannot affect it.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int VA_W   = 32;
    localparam int ASID_W = 8;
    localparam logic [VA_W-1:0] PHYS_KEEP = 32'h1FFF_FFFF;

    typedef enum logic [2:0] {
        EXC_NONE        = 3'd0,
        EXC_LOAD_MISS   = 3'd1,
        EXC_STORE_MISS  = 3'd2,
        EXC_LOAD_PROT   = 3'd3,
        EXC_STORE_PROT  = 3'd4,
        EXC_FIRST_WRITE = 3'd5
    } tlb_exc_e;

    typedef struct packed {
        logic              valid;
        logic [VA_W-1:0]   vtag;
        logic [ASID_W-1:0] asid;
        logic [VA_W-1:0]   pdata;
        logic [1:0]        size;
        logic [1:0]        prot;
        logic              shared;
        logic              dirty;
    } tlb_entry_t;

    // Compare mask for a size code: wider pages keep fewer tag bits.
    function automatic logic [VA_W-1:0] page_mask(input logic [1:0] sz);
        logic [VA_W-1:0] m;
        case (sz)
            2'd0:    m = 32'hFFFF_FC00;
            2'd1:    m = 32'hFFFF_F000;
            2'd2:    m = 32'hFFFF_0000;
            default: m = 32'hFFF0_0000;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter  int N  = 64,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  tlb_entry_t [N-1:0]  ents,
    input  logic [VA_W-1:0]     vaddr,
    input  logic [ASID_W-1:0]   asid,
    input  logic                waive,
    output logic                hit,
    output logic [IW-1:0]       idx
);

    logic [N-1:0] sel;

    // One comparator per entry: tag under the entry's own mask, then
    // the identifier filter with its two bypasses.
    for (genvar g = 0; g < N; g++) begin : g_cmp
        logic tag_eq;
        logic id_ok;
        assign tag_eq = ((ents[g].vtag ^ vaddr) & page_mask(ents[g].size)) == '0;
        assign id_ok  = ents[g].shared || waive || (ents[g].asid == asid);
        assign sel[g] = ents[g].valid && tag_eq && id_ok;
    end

    always_comb begin
        hit = |sel;
        idx = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (sel[k]) idx = IW'(k);
        end
    end

endmodule

// File: rtl/tlb_perm.sv
module tlb_perm
    import tlb_pkg::*;
(
    input  logic       hit,
    input  logic [1:0] prot,
    input  logic       dirty,
    input  logic       write,
    input  logic       fetch,
    input  logic       priv,
    output tlb_exc_e   code
);

    logic store;

    always_comb begin
        store = write && !fetch;
        code  = EXC_NONE;
        if (!hit) begin
            code = store ? EXC_STORE_MISS : EXC_LOAD_MISS;
        end else if (fetch) begin
            if (!priv && !prot[1]) code = EXC_LOAD_PROT;
        end else if (priv) begin
            case (prot)
                2'd0, 2'd2: if (store) code = EXC_STORE_PROT;
                default:    if (store && !dirty) code = EXC_FIRST_WRITE;
            endcase
        end else begin
            case (prot)
                2'd0, 2'd1: code = store ? EXC_STORE_PROT : EXC_LOAD_PROT;
                2'd2:       if (store) code = EXC_STORE_PROT;
                default:    if (store && !dirty) code = EXC_FIRST_WRITE;
            endcase
        end
    end

    always_comb begin
        if (hit && fetch && priv) begin
            a_priv_fetch_r7: assert (code == EXC_NONE)
                else $error("privileged fetch faulted");
        end
    end

endmodule

// File: rtl/tlb_repl.sv
module tlb_repl #(
    parameter  int N      = 64,
    parameter  int SLOT_W = 2,
    localparam int IW     = (N > 1) ? $clog2(N) : 1,
    localparam int LW     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic [IW-1:0]     bound,
    output logic [IW-1:0]     count,
    output logic [SLOT_W-1:0] slot
);

    typedef struct packed {
        logic [IW-1:0] cnt;
        logic [LW-1:0] lfsr;
    } repl_state_t;

    repl_state_t d, q;
    logic [IW:0] inc;
    logic        wrap;

    always_comb begin
        d    = q;
        inc  = {1'b0, q.cnt} + 1'b1;
        wrap = (inc == (IW+1)'(N)) || ((bound != '0) && (inc == {1'b0, bound}));
        if (step) d.cnt = wrap ? '0 : inc[IW-1:0];
        // Free-running maximal-length shift register for slot choice.
        d.lfsr = {q.lfsr[LW-2:0], q.lfsr[7] ^ q.lfsr[5] ^ q.lfsr[4] ^ q.lfsr[3]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.cnt  <= '0;
            q.lfsr <= LW'(1);
        end else begin
            q <= d;
        end
    end

    assign count = q.cnt;
    assign slot  = q.lfsr[SLOT_W-1:0];

    p_count_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (count == '0) || (count == $past(count) + 1'b1));

    p_count_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(count));

endmodule

// File: rtl/tlb_unit.sv
module tlb_unit
    import tlb_pkg::*;
#(
    parameter  int UN  = 64,
    parameter  int IN  = 4,
    localparam int UIW = $clog2(UN),
    localparam int ISW = $clog2(IN)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    input  logic [31:0]    req_vaddr,
    input  logic           req_write,
    input  logic           req_fetch,
    input  logic           req_probe,
    input  logic [7:0]     cur_asid,
    input  logic           priv_mode,
    input  logic           single_virt,
    input  logic [UIW-1:0] repl_bound,
    input  logic           ent_wr_utlb,
    input  logic           ent_wr_itlb,
    input  logic [UIW-1:0] ent_index,
    input  logic           ent_valid,
    input  logic [31:0]    ent_vtag,
    input  logic [7:0]     ent_asid,
    input  logic [31:0]    ent_pdata,
    input  logic [1:0]     ent_size,
    input  logic [1:0]     ent_prot,
    input  logic           ent_shared,
    input  logic           ent_dirty,
    output logic           rsp_valid,
    output logic [31:0]    rsp_paddr,
    output logic [2:0]     rsp_exc,
    output logic           rsp_fault,
    output logic           rsp_itlb_hit,
    output logic [UIW-1:0] repl_count
);

    typedef struct packed {
        tlb_entry_t [UN-1:0] u;
        tlb_entry_t [IN-1:0] i;
        logic                rv;
        logic [VA_W-1:0]     pa;
        tlb_exc_e            exc;
        logic                fault;
        logic                ihit;
        logic                probe;
    } unit_state_t;

    unit_state_t d, q;

    logic            waive;
    logic            u_hit, i_hit, use_i, any_hit, refill;
    logic [UIW-1:0]  u_idx;
    logic [ISW-1:0]  i_idx, fill_slot;
    tlb_entry_t      pick, wr_ent;
    tlb_exc_e        code;
    logic [VA_W-1:0] msk, pa;

    assign waive = single_virt && priv_mode;

    tlb_match #(.N(UN)) u_match (
        .ents(q.u), .vaddr(req_vaddr), .asid(cur_asid), .waive(waive),
        .hit(u_hit), .idx(u_idx)
    );

    tlb_match #(.N(IN)) i_match (
        .ents(q.i), .vaddr(req_vaddr), .asid(cur_asid), .waive(waive),
        .hit(i_hit), .idx(i_idx)
    );

    tlb_repl #(.N(UN), .SLOT_W(ISW)) u_repl (
        .clk(clk), .rst_n(rst_n),
        .step(req_valid && !req_probe),
        .bound(repl_bound), .count(repl_count), .slot(fill_slot)
    );

    always_comb begin
        use_i   = req_fetch && i_hit;
        any_hit = use_i || u_hit;
        pick    = use_i ? q.i[i_idx] : q.u[u_idx];
        refill  = req_valid && req_fetch && !i_hit && u_hit;
        msk     = page_mask(pick.size);
        pa      = (req_vaddr & ~msk) | (pick.pdata & msk & PHYS_KEEP);
    end

    tlb_perm u_perm (
        .hit(any_hit), .prot(pick.prot), .dirty(pick.dirty),
        .write(req_write), .fetch(req_fetch), .priv(priv_mode),
        .code(code)
    );

    always_comb begin
        wr_ent.valid  = ent_valid;
        wr_ent.vtag   = ent_vtag;
        wr_ent.asid   = ent_asid;
        wr_ent.pdata  = ent_pdata;
        wr_ent.size   = ent_size;
        wr_ent.prot   = ent_prot;
        wr_ent.shared = ent_shared;
        wr_ent.dirty  = ent_dirty;

        d    = q;
        d.rv = req_valid;
        if (req_valid) begin
            d.fault = (code != EXC_NONE);
            d.pa    = d.fault ? '0 : pa;
            d.exc   = req_probe ? EXC_NONE : code;
            d.ihit  = use_i;
            d.probe = req_probe;
        end
        if (refill) d.i[fill_slot] = q.u[u_idx];
        // An explicit write lands after the refill and so wins a clash.
        if (ent_wr_utlb) d.u[ent_index] = wr_ent;
        if (ent_wr_itlb) d.i[ent_index[ISW-1:0]] = wr_ent;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rsp_valid    = q.rv;
    assign rsp_paddr    = q.pa;
    assign rsp_exc      = q.exc;
    assign rsp_fault    = q.fault;
    assign rsp_itlb_hit = q.ihit;

    p_rsp_follows_r13: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_rsp_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    p_probe_silent_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && q.probe) |-> (rsp_exc == 3'd0));

    p_fault_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));

    p_exc_matches_fault_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !q.probe) |-> (rsp_fault == (rsp_exc != 3'd0)));

    p_priv_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_fetch && priv_mode) |=> (rsp_exc != 3'd3));

    p_data_no_itlb_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_fetch) |=> !rsp_itlb_hit);

endmodule

// File: tb/tlb_unit_test.sv
module tlb_unit_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write, req_fetch, req_probe;
    logic [31:0] req_vaddr;
    logic [7:0]  cur_asid;
    logic        priv_mode, single_virt;
    logic [5:0]  repl_bound;
    logic        ent_wr_utlb, ent_wr_itlb;
    logic [5:0]  ent_index;
    logic        ent_valid, ent_shared, ent_dirty;
    logic [31:0] ent_vtag, ent_pdata;
    logic [7:0]  ent_asid;
    logic [1:0]  ent_size, ent_prot;
    logic        rsp_valid, rsp_fault, rsp_itlb_hit;
    logic [31:0] rsp_paddr;
    logic [2:0]  rsp_exc;
    logic [5:0]  repl_count;

    always #5 clk = ~clk;

    tlb_unit uut (.*);

    typedef struct {
        bit          v;
        int unsigned tag;
        int          asid;
        int unsigned pd;
        int          sz;
        int          pr;
        bit          sh;
        bit          d;
    } ment_t;

    ment_t       mu[64];
    ment_t       mi[4];
    bit          itrust;
    bit          fill_known;
    int unsigned fill_tag, fill_mask;
    int          cnt;
    int          checks, fails;
    bit          done;

    bit          exp_v, exp_f;
    int unsigned exp_pa;
    int          exp_exc, exp_ih;
    string       exp_tag;

    function automatic int unsigned size_to_mask(int sz);
        int unsigned span;
        span = (sz == 0) ? 1024 : (sz == 1) ? 4096 : (sz == 2) ? 65536 : 1048576;
        return ~(span - 1);
    endfunction

    function automatic bit ent_match(ment_t e, int unsigned va);
        int unsigned m;
        m = size_to_mask(e.sz);
        if (!e.v) return 0;
        if ((e.tag & m) != (va & m)) return 0;
        if (e.sh || (single_virt && priv_mode)) return 1;
        return e.asid == int'(cur_asid);
    endfunction

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_now();
        chk(rsp_valid == exp_v, exp_tag, "rsp_valid", rsp_valid, exp_v);
        chk(int'(repl_count) == cnt, exp_tag, "repl_count", repl_count, cnt);
        if (exp_v) begin
            chk(rsp_paddr == exp_pa, exp_tag, "rsp_paddr", rsp_paddr, exp_pa);
            chk(int'(rsp_exc) == exp_exc, exp_tag, "rsp_exc", rsp_exc, exp_exc);
            chk(rsp_fault == exp_f, exp_tag, "rsp_fault", rsp_fault, exp_f);
            if (exp_ih >= 0)
                chk(int'(rsp_itlb_hit) == exp_ih, exp_tag, "rsp_itlb_hit", rsp_itlb_hit, exp_ih);
        end
    endtask

    task automatic idle(string tg);
        exp_v = 0; exp_tag = tg;
        @(negedge clk);
        compare_now();
    endtask

    task automatic do_req(string tg, int unsigned va, bit wr, bit fe, bit pb);
        ment_t e;
        bit    found, from_i, readable, writable;
        int    code;
        int unsigned m;
        found = 0; from_i = 0;
        if (fe && itrust) begin
            for (int k = 0; k < 4; k++)
                if (!found && ent_match(mi[k], va)) begin found = 1; from_i = 1; e = mi[k]; end
        end
        for (int k = 0; k < 64; k++)
            if (!found && ent_match(mu[k], va)) begin found = 1; e = mu[k]; end
        exp_ih = fe ? -1 : 0;
        if (fe && itrust) exp_ih = from_i;
        if (fe && !found) exp_ih = (itrust || !fill_known) ? 0 : -1;
        if (fe && found && !from_i) begin
            m = size_to_mask(e.sz);
            if (!itrust && fill_known && ((va & fill_mask) == (fill_tag & fill_mask)))
                exp_ih = 1;
            itrust = 0; fill_known = 1; fill_tag = e.tag; fill_mask = m;
        end
        code = 0;
        if (!found) code = (wr && !fe) ? 2 : 1;
        else if (fe) begin
            if (!(priv_mode || e.pr >= 2)) code = 3;
        end else begin
            readable = priv_mode ? 1'b1 : (e.pr >= 2);
            writable = priv_mode ? (e.pr == 1 || e.pr == 3) : (e.pr == 3);
            if (wr && !writable) code = 4;
            else if (!wr && !readable) code = 3;
            else if (wr && !e.d) code = 5;
        end
        exp_v = 1; exp_tag = tg; exp_f = (code != 0);
        exp_exc = pb ? 0 : code;
        if (exp_f) exp_pa = 0;
        else begin
            m = size_to_mask(e.sz);
            exp_pa = (va & ~m) | (e.pd & m & 32'h1FFF_FFFF);
        end
        if (!pb) cnt = ((cnt + 1 == 64) || (repl_bound != 0 && cnt + 1 == int'(repl_bound))) ? 0 : cnt + 1;
        req_valid = 1; req_vaddr = va; req_write = wr; req_fetch = fe; req_probe = pb;
        @(negedge clk);
        compare_now();
        req_valid = 0; req_write = 0; req_fetch = 0; req_probe = 0;
    endtask

    task automatic wr_ent(bit to_u, int idx, ment_t e, string tg);
        ent_wr_utlb = to_u; ent_wr_itlb = !to_u; ent_index = 6'(idx);
        ent_valid = e.v; ent_vtag = e.tag; ent_asid = 8'(e.asid); ent_pdata = e.pd;
        ent_size = 2'(e.sz); ent_prot = 2'(e.pr); ent_shared = e.sh; ent_dirty = e.d;
        if (to_u) mu[idx] = e; else mi[idx] = e;
        exp_v = 0; exp_tag = tg;
        @(negedge clk);
        compare_now();
        ent_wr_utlb = 0; ent_wr_itlb = 0;
    endtask

    function automatic ment_t mk(bit v, int unsigned tag, int asid, int unsigned pd,
                                 int sz, int pr, bit sh, bit d);
        ment_t e;
        e.v = v; e.tag = tag; e.asid = asid; e.pd = pd; e.sz = sz; e.pr = pr; e.sh = sh; e.d = d;
        return e;
    endfunction

    task automatic clear_itlb();
        for (int k = 0; k < 4; k++) wr_ent(0, k, mk(0, 0, 0, 0, 0, 0, 0, 0), "R6");
        itrust = 1; fill_known = 0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        checks = 0; fails = 0; done = 0; cnt = 0; itrust = 1; fill_known = 0;
        for (int k = 0; k < 64; k++) mu[k] = mk(0, 0, 0, 0, 0, 0, 0, 0);
        for (int k = 0; k < 4; k++) mi[k] = mk(0, 0, 0, 0, 0, 0, 0, 0);
        rst_n = 0; req_valid = 0; req_vaddr = 0; req_write = 0; req_fetch = 0; req_probe = 0;
        cur_asid = 5; priv_mode = 1; single_virt = 0; repl_bound = 0;
        ent_wr_utlb = 0; ent_wr_itlb = 0; ent_index = 0; ent_valid = 0; ent_vtag = 0;
        ent_asid = 0; ent_pdata = 0; ent_size = 0; ent_prot = 0; ent_shared = 0; ent_dirty = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        idle("R1");
        do_req("R1", 32'h0040_0000, 0, 0, 0);   // every entry invalid after reset

        wr_ent(1, 0,  mk(1, 32'h0040_0000, 5, 32'h1234_5000, 1, 3, 0, 1), "R13");
        wr_ent(1, 1,  mk(1, 32'h0050_0400, 5, 32'hFFFF_F800, 0, 2, 0, 1), "R13");
        wr_ent(1, 2,  mk(1, 32'h1230_0000, 7, 32'h0ABC_0000, 2, 1, 1, 0), "R13");
        wr_ent(1, 3,  mk(1, 32'h7FF0_0000, 9, 32'h2010_0000, 3, 0, 0, 0), "R13");
        wr_ent(1, 4,  mk(0, 32'h0060_0000, 5, 32'h0333_3000, 1, 3, 0, 1), "R3");
        wr_ent(1, 63, mk(1, 32'h0070_0000, 5, 32'h0444_4000, 1, 3, 0, 0), "R13");

        // page sizes and address formation
        do_req("R5", 32'h0040_0ABC, 0, 0, 0);
        do_req("R2", 32'h0050_07FF, 0, 0, 0);
        do_req("R2", 32'h0050_0800, 0, 0, 0);
        do_req("R2", 32'h1234_5678, 0, 0, 0);
        do_req("R2", 32'h1231_0000, 0, 0, 0);
        do_req("R4", 32'h7FFA_BCDE, 0, 0, 0);
        single_virt = 1;
        do_req("R4", 32'h7FFA_BCDE, 0, 0, 0);
        priv_mode = 0;
        do_req("R4", 32'h7FFA_BCDE, 0, 0, 0);
        priv_mode = 1; single_virt = 0;
        // valid flag
        do_req("R3", 32'h0060_0010, 0, 0, 0);
        wr_ent(1, 4, mk(1, 32'h0060_0000, 5, 32'h0333_3000, 1, 3, 0, 1), "R3");
        do_req("R3", 32'h0060_0010, 0, 0, 0);
        idle("R13");

        // privileged data permissions
        do_req("R8", 32'h0050_0500, 1, 0, 0);
        do_req("R8", 32'h0040_0010, 1, 0, 0);
        do_req("R8", 32'h0070_0020, 1, 0, 0);
        do_req("R8", 32'h1230_0040, 1, 0, 0);
        do_req("R8", 32'h1230_0040, 0, 0, 0);
        single_virt = 1;
        do_req("R8", 32'h7FF0_0100, 0, 0, 0);
        do_req("R8", 32'h7FF0_0100, 1, 0, 0);
        single_virt = 0;

        // user data permissions
        priv_mode = 0; cur_asid = 9;
        do_req("R9", 32'h7FF0_0100, 0, 0, 0);
        do_req("R9", 32'h7FF0_0100, 1, 0, 0);
        do_req("R9", 32'h1230_0004, 0, 0, 0);
        do_req("R9", 32'h1230_0004, 1, 0, 0);
        cur_asid = 5;
        do_req("R9", 32'h0050_0404, 0, 0, 0);
        do_req("R9", 32'h0050_0404, 1, 0, 0);
        do_req("R9", 32'h0040_0404, 1, 0, 0);
        do_req("R9", 32'h0070_0404, 1, 0, 0);
        priv_mode = 1;

        // misses
        do_req("R10", 32'h3000_0000, 1, 0, 0);
        do_req("R10", 32'h3000_0000, 0, 0, 0);

        // probes
        do_req("R12", 32'h3000_0000, 1, 0, 1);
        do_req("R12", 32'h0050_0500, 1, 0, 1);
        do_req("R12", 32'h0040_0ABC, 0, 0, 1);
        idle("R12");

        // replacement counter
        for (int k = 0; k < 70; k++) do_req("R11", 32'h0040_0000 + 32'(k), 0, 0, 0);
        repl_bound = 10;
        for (int k = 0; k < 80; k++) do_req("R11", 32'h0040_0100, 0, 0, 0);
        repl_bound = 1;
        for (int k = 0; k < 4; k++) do_req("R11", 32'h0040_0100, 0, 0, 0);
        repl_bound = 0;
        idle("R11");

        // instruction array and fetch permissions
        clear_itlb();
        wr_ent(0, 2, mk(1, 32'h0040_0000, 5, 32'h0555_5000, 1, 2, 0, 1), "R6");
        do_req("R6", 32'h0040_0123, 0, 1, 0);
        priv_mode = 0;
        do_req("R7", 32'h0040_0124, 0, 1, 0);
        do_req("R6", 32'h0070_0010, 0, 1, 0);
        do_req("R6", 32'h0070_0014, 0, 1, 0);
        do_req("R6", 32'h0070_0018, 0, 0, 0);
        do_req("R7", 32'h1230_0000, 0, 1, 0);
        do_req("R7", 32'h1230_0000, 0, 1, 0);
        priv_mode = 1; cur_asid = 9;
        do_req("R7", 32'h7FF0_0200, 0, 1, 0);
        do_req("R10", 32'h3000_1000, 1, 1, 0);
        idle("R13");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule